// File: doc/BRIEF.md
# Keyed Clock Post-Divider with Delayed Copy

This block divides a fast source clock by an integer from 1 to 128 and produces two outputs: the divided clock and a copy of it that lags by 0 to 3 source cycles. The copy can be inverted or switched off. Both settings are loaded through guarded writes. Each write carries a fixed key next to the value it sets. A write with a wrong key, or with a value out of range, still loads a safe setting and raises a one-cycle bad-write pulse. A running flag reports that the divider is active.

The block sits after an oscillator in a clock generator. Register decoding happens elsewhere. This block only sees two write strobes and a shared 16-bit data word.

A new divisor waits for the end of the current output period before it takes effect. Changes to the phase settings take effect on the next source cycle. The delay line keeps running while the copy is off, so enabling it again gives the correct phase at once.

Top module: `rdiv_top`

## Requirements
- R1: A divisor write with data[15:8] = 0xAA and data[7:0] = v sets the divisor to v for v in 1..127, and to 128 for v = 0.
- R2: A divisor write whose data[15:8] is not 0xAA, or whose data[7:0] is 128 or more, sets the divisor to 128. Any rejected divisor or phase write raises bad_write_o for exactly the one cycle after the write clock edge.
- R3: While reset is held, clk_div_o, clk_phase_o, running_o and bad_write_o are low. After reset the divisor is 32, and the delayed copy is enabled with shift 0 and no inversion.
- R4: For a divisor N of 2 or more, clk_div_o is high for floor(N/2) source cycles and low for the remaining cycles of each period.
- R5: A new divisor takes effect only at the next rising edge of clk_div_o. The period in progress completes with the old divisor.
- R6: A phase write with data[11:4] = 0xAA loads enable from bit 3, invert from bit 2 and shift from bits 1:0. clk_phase_o then equals clk_div_o delayed by shift source cycles, XOR invert.
- R7: A phase write with any other key in data[11:4] sets enable = 1, shift = 0 and invert = 0.
- R8: While the delayed copy is disabled, clk_phase_o is low. When it is enabled again, clk_phase_o has the correct delayed value from the first cycle.
- R9: With divisor 1, clk_div_o is the source clock. clk_phase_o is the source clock gated by the enable bit. Shift and invert have no effect.
- R10: running_o goes high at the first source edge after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | Strobe: load the divisor from wr_data_i |
| phase_wr_i | input | 1 | Strobe: load the phase settings from wr_data_i |
| wr_data_i | input | 16 | Key plus value for either write |
| clk_div_o | output | 1 | Divided clock |
| clk_phase_o | output | 1 | Delayed, optionally inverted copy of the divided clock |
| running_o | output | 1 | The divider is active |
| bad_write_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The divisor is tried with these values:
- even, odd and zero-coded values, which separate the floor(N/2) high time from the remainder and confirm that zero means 128;
- a wrong key and an out-of-range value, which must fall back to 128 rather than keep the old setting;
- divide-by-1, where the outputs follow the source clock itself.

A write made in the middle of a high phase shows whether the running period finishes with the old divisor.

The delayed copy is compared against a record of past divided-clock samples for each of these:
- each shift value;
- the inverted setting;
- the disabled setting;
- enabling the copy again straight after disabling it, which shows that the delay line kept running.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // divisor value field width; divisors span 1 .. 2**DIV_W
    localparam int DIV_W    = 7;
    localparam int DIVV_W   = DIV_W + 1;
    localparam int LO_W     = DIV_W + 1;
    localparam int KEY_W    = 8;
    localparam int WR_W     = LO_W + KEY_W;
    localparam int SH_W     = 2;
    localparam int DLY_N    = (1 << SH_W) - 1;
    localparam int PKEY_LSB = SH_W + 2;

    typedef struct packed {
        logic [DIVV_W-1:0] div;
        logic              en;
        logic              flip;
        logic [SH_W-1:0]   shift;
        logic              bad;
    } cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [DIVV_W-1:0] act;
        logic              out;
    } core_t;

endpackage

// File: rtl/rdiv_cfg.sv
module rdiv_cfg
    import rdiv_pkg::*;
#(
    parameter logic [KEY_W-1:0]  DIV_KEY   = 8'hAA,
    parameter logic [KEY_W-1:0]  PH_KEY    = 8'hAA,
    parameter logic [DIVV_W-1:0] DIV_RESET = 8'd32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              div_wr_i,
    input  logic              phase_wr_i,
    input  logic [WR_W-1:0]   wr_data_i,
    output logic [DIVV_W-1:0] pend_div_o,
    output logic              en_o,
    output logic              flip_o,
    output logic [SH_W-1:0]   shift_o,
    output logic              bad_o
);

    localparam logic [DIVV_W-1:0] MAX_DIV = DIVV_W'(1) << DIV_W;

    cfg_t cfg_d, cfg_q;

    logic [KEY_W-1:0] div_key, ph_key;
    logic [LO_W-1:0]  lo_val;
    logic             div_ok, ph_ok;

    always_comb begin
        div_key = wr_data_i[WR_W-1:LO_W];
        lo_val  = wr_data_i[LO_W-1:0];
        ph_key  = wr_data_i[PKEY_LSB+KEY_W-1:PKEY_LSB];
        div_ok  = (div_key == DIV_KEY) && !lo_val[LO_W-1];
        ph_ok   = (ph_key == PH_KEY);

        cfg_d     = cfg_q;
        cfg_d.bad = 1'b0;

        if (div_wr_i) begin
            if (div_ok && (lo_val[LO_W-2:0] != '0)) begin
                cfg_d.div = {1'b0, lo_val[LO_W-2:0]};
            end else begin
                cfg_d.div = MAX_DIV;
            end
            if (!div_ok) begin
                cfg_d.bad = 1'b1;
            end
        end

        if (phase_wr_i) begin
            if (ph_ok) begin
                cfg_d.en    = wr_data_i[SH_W+1];
                cfg_d.flip  = wr_data_i[SH_W];
                cfg_d.shift = wr_data_i[SH_W-1:0];
            end else begin
                cfg_d.en    = 1'b1;
                cfg_d.flip  = 1'b0;
                cfg_d.shift = '0;
                cfg_d.bad   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.div   <= DIV_RESET;
            cfg_q.en    <= 1'b1;
            cfg_q.flip  <= 1'b0;
            cfg_q.shift <= '0;
            cfg_q.bad   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pend_div_o = cfg_q.div;
    assign en_o       = cfg_q.en;
    assign flip_o     = cfg_q.flip;
    assign shift_o    = cfg_q.shift;
    assign bad_o      = cfg_q.bad;

endmodule

// File: rtl/rdiv_core.sv
module rdiv_core
    import rdiv_pkg::*;
#(
    parameter logic [DIVV_W-1:0] DIV_RESET = 8'd32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIVV_W-1:0] pend_div_i,
    output logic              out_o,
    output logic [DIVV_W-1:0] act_div_o,
    output logic              div_one_o
);

    core_t core_d, core_q;
    logic  wrap;

    always_comb begin
        // last count of the period: the next edge starts a new rising edge
        wrap   = ({1'b0, core_q.cnt} == (core_q.act - 1'b1));
        core_d = core_q;
        if (wrap) begin
            core_d.cnt = '0;
            core_d.act = pend_div_i;
        end else begin
            core_d.cnt = core_q.cnt + 1'b1;
        end
        core_d.out = ({1'b0, core_d.cnt} < (core_d.act >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q.cnt <= DIV_W'(DIV_RESET - 1'b1);
            core_q.act <= DIV_RESET;
            core_q.out <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign out_o     = core_q.out;
    assign act_div_o = core_q.act;
    assign div_one_o = (core_q.act == DIVV_W'(1));

endmodule

// File: rtl/rdiv_phase.sv
module rdiv_phase
    import rdiv_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            div_i,
    input  logic            en_i,
    input  logic            flip_i,
    input  logic [SH_W-1:0] shift_i,
    output logic            phase_o
);

    logic [DLY_N-1:0] dly_d, dly_q;
    logic [DLY_N:0]   taps;

    always_comb begin
        dly_d[0] = div_i;
        taps[0]  = div_i;
    end

    for (genvar i = 1; i < DLY_N; i++) begin : g_stage
        always_comb dly_d[i] = dly_q[i-1];
    end

    for (genvar i = 1; i <= DLY_N; i++) begin : g_tap
        always_comb taps[i] = dly_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    assign phase_o = en_i & (taps[shift_i] ^ flip_i);

endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
    import rdiv_pkg::*;
#(
    parameter logic [KEY_W-1:0]  DIV_KEY   = 8'hAA,
    parameter logic [KEY_W-1:0]  PH_KEY    = 8'hAA,
    parameter logic [DIVV_W-1:0] DIV_RESET = 8'd32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            div_wr_i,
    input  logic            phase_wr_i,
    input  logic [WR_W-1:0] wr_data_i,
    output logic            clk_div_o,
    output logic            clk_phase_o,
    output logic            running_o,
    output logic            bad_write_o
);

    logic [DIVV_W-1:0] pend_div, act_div;
    logic              ph_en, ph_flip, core_out, div_one, phase_raw;
    logic [SH_W-1:0]   ph_shift;
    logic              run_d, run_q;

    rdiv_cfg #(
        .DIV_KEY  (DIV_KEY),
        .PH_KEY   (PH_KEY),
        .DIV_RESET(DIV_RESET)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_wr_i  (div_wr_i),
        .phase_wr_i(phase_wr_i),
        .wr_data_i (wr_data_i),
        .pend_div_o(pend_div),
        .en_o      (ph_en),
        .flip_o    (ph_flip),
        .shift_o   (ph_shift),
        .bad_o     (bad_write_o)
    );

    rdiv_core #(
        .DIV_RESET(DIV_RESET)
    ) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pend_div_i(pend_div),
        .out_o     (core_out),
        .act_div_o (act_div),
        .div_one_o (div_one)
    );

    rdiv_phase u_phase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (core_out),
        .en_i   (ph_en),
        .flip_i (ph_flip),
        .shift_i(ph_shift),
        .phase_o(phase_raw)
    );

    always_comb run_d = 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    // divide-by-one bypasses the counter; shift and invert drop out there
    assign clk_div_o   = div_one ? clk_i : core_out;
    assign clk_phase_o = div_one ? (clk_i & ph_en) : phase_raw;
    assign running_o   = run_q;

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker
    import rdiv_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              div_wr_i,
    input logic              phase_wr_i,
    input logic              bad_write_o,
    input logic              running_o,
    input logic              clk_phase_o,
    input logic              core_out,
    input logic [DIVV_W-1:0] act_div,
    input logic              div_one,
    input logic              ph_en,
    input logic              ph_flip,
    input logic [SH_W-1:0]   ph_shift
);

    localparam logic [DIVV_W-1:0] MAX_DIV = DIVV_W'(1) << DIV_W;

    assert_div_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_div >= DIVV_W'(1)) && (act_div <= MAX_DIV));

    assert_bad_follows_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_write_o |-> $past(div_wr_i || phase_wr_i));

    assert_switch_at_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act_div != $past(act_div)) && !div_one) |-> core_out);

    assert_one_cycle_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div_one && ph_en && !ph_flip && (ph_shift == SH_W'(1)))
            |-> (clk_phase_o == $past(core_out)));

    assert_running_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(running_o) |-> running_o);

endmodule

bind rdiv_top rdiv_checker i_rdiv_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_wr_i   (div_wr_i),
    .phase_wr_i (phase_wr_i),
    .bad_write_o(bad_write_o),
    .running_o  (running_o),
    .clk_phase_o(clk_phase_o),
    .core_out   (core_out),
    .act_div    (act_div),
    .div_one    (div_one),
    .ph_en      (ph_en),
    .ph_flip    (ph_flip),
    .ph_shift   (ph_shift)
);

// File: tb/test_rdiv_top.sv
module test_rdiv_top;

    localparam int CYC = 4;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        div_wr_i = 1'b0;
    logic        phase_wr_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        clk_div_o, clk_phase_o, running_o, bad_write_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] hist = '0;

    always #(CYC/2) clk_i = ~clk_i;

    rdiv_top i_rdiv_top (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .div_wr_i   (div_wr_i),
        .phase_wr_i (phase_wr_i),
        .wr_data_i  (wr_data_i),
        .clk_div_o  (clk_div_o),
        .clk_phase_o(clk_phase_o),
        .running_o  (running_o),
        .bad_write_o(bad_write_o)
    );

    // hist[k] = divided clock k source cycles ago, sampled at each falling edge
    always @(negedge clk_i) hist = {hist[2:0], clk_div_o};

    // data, expected high, expected low, expected bad pulse
    localparam logic [39:0] VEC [0:7] = '{
        {16'hAA08, 8'd4,  8'd4,  8'd0},   // R1 even
        {16'hAA07, 8'd3,  8'd4,  8'd0},   // R1 odd
        {16'hAA00, 8'd64, 8'd64, 8'd0},   // R1 zero means 128
        {16'hAA02, 8'd1,  8'd1,  8'd0},   // R4 smallest counted
        {16'hAA7F, 8'd63, 8'd64, 8'd0},   // R4 largest value
        {16'hAB05, 8'd64, 8'd64, 8'd1},   // R2 wrong key
        {16'hAA85, 8'd64, 8'd64, 8'd1},   // R2 value out of range
        {16'hAA03, 8'd1,  8'd2,  8'd0}    // R4 odd small
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_i);
        #1;
    endtask

    task automatic wr_div(input logic [15:0] d, input int exp_bad, input string req);
        div_wr_i  = 1'b1;
        wr_data_i = d;
        step();
        div_wr_i = 1'b0;
        check(bad_write_o == exp_bad, req, bad_write_o, exp_bad);
        step();
        check(bad_write_o == 1'b0, req, bad_write_o, 0);
    endtask

    task automatic wr_phase(input logic [15:0] d, input int exp_bad, input string req);
        phase_wr_i = 1'b1;
        wr_data_i  = d;
        step();
        phase_wr_i = 1'b0;
        check(bad_write_o == exp_bad, req, bad_write_o, exp_bad);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = clk_div_o;
        forever begin
            step();
            if (!prev && clk_div_o) break;
            prev = clk_div_o;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        wait_rise();
        hi = 0;
        while (clk_div_o) begin hi++; step(); end
        lo = 0;
        while (!clk_div_o) begin lo++; step(); end
    endtask

    task automatic check_phase(input logic en, input logic flip, input int sh,
                               input string req);
        int bad_n = 0;
        logic exp_v = 1'b0;
        for (int k = 0; k < 24; k++) begin
            exp_v = en & (hist[sh] ^ flip);
            if (clk_phase_o !== exp_v) bad_n++;
            step();
        end
        check(bad_n == 0, req, bad_n, 0);
    endtask

    initial begin
        #(CYC * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo;

        // R3 reset state
        step(); step(); step();
        check(clk_div_o == 1'b0,   "R3 div in reset", clk_div_o, 0);
        check(clk_phase_o == 1'b0, "R3 phase in reset", clk_phase_o, 0);
        check(running_o == 1'b0,   "R10 running in reset", running_o, 0);
        check(bad_write_o == 1'b0, "R3 bad in reset", bad_write_o, 0);
        rst_ni = 1'b1;
        step();
        check(running_o == 1'b1, "R10 running after first edge", running_o, 1);
        check(clk_div_o == 1'b1, "R3 first rise", clk_div_o, 1);
        measure(hi, lo);
        check(hi == 16, "R3 default high", hi, 16);
        check(lo == 16, "R3 default low", lo, 16);
        check_phase(1'b1, 1'b0, 0, "R3 default phase");

        // table: R1 R2 R4
        for (int v = 0; v < 8; v++) begin
            wr_div(VEC[v][39:24], int'(VEC[v][7:0]), "R2 bad pulse");
            measure(hi, lo);
            check(hi == int'(VEC[v][23:16]), "R1 R4 high time", hi, int'(VEC[v][23:16]));
            check(lo == int'(VEC[v][15:8]),  "R1 R4 low time",  lo, int'(VEC[v][15:8]));
        end

        // R5: write in the middle of a high phase
        wr_div(16'hAA0A, 0, "R5 setup");
        measure(hi, lo);
        wait_rise();
        div_wr_i  = 1'b1;
        wr_data_i = 16'hAA04;
        hi = 1;
        step();
        div_wr_i = 1'b0;
        while (clk_div_o) begin hi++; step(); end
        lo = 0;
        while (!clk_div_o) begin lo++; step(); end
        check(hi == 5, "R5 old period high", hi, 5);
        check(lo == 5, "R5 old period low", lo, 5);
        measure(hi, lo);
        check(hi == 2 && lo == 2, "R5 new period", hi * 100 + lo, 202);

        // phase tests at divisor 8
        wr_div(16'hAA08, 0, "R6 setup");
        measure(hi, lo);
        wr_phase(16'h0AA9, 0, "R6 write");
        check_phase(1'b1, 1'b0, 1, "R6 shift 1");
        wr_phase(16'h0AAB, 0, "R6 write");
        check_phase(1'b1, 1'b0, 3, "R6 shift 3");
        wr_phase(16'h0AAE, 0, "R6 write");
        check_phase(1'b1, 1'b1, 2, "R6 invert shift 2");
        wr_phase(16'h0AA2, 0, "R8 write");
        check_phase(1'b0, 1'b0, 2, "R8 disabled low");
        wr_phase(16'h0AAA, 0, "R8 write");
        check_phase(1'b1, 1'b0, 2, "R8 re-enable at once");
        wr_phase(16'h0BB7, 1, "R7 bad key pulse");
        check_phase(1'b1, 1'b0, 0, "R7 fallback phase");

        // R9 divide by one
        wr_phase(16'h0AAC, 0, "R9 write");
        wr_div(16'hAA01, 0, "R9 write");
        repeat (20) step();
        check(clk_div_o == 1'b0,   "R9 div low half", clk_div_o, 0);
        check(clk_phase_o == 1'b0, "R9 invert ignored low", clk_phase_o, 0);
        @(posedge clk_i); #1;
        check(clk_div_o == 1'b1,   "R9 div high half", clk_div_o, 1);
        check(clk_phase_o == 1'b1, "R9 invert ignored high", clk_phase_o, 1);
        step();
        wr_phase(16'h0AA0, 0, "R9 write");
        @(posedge clk_i); #1;
        check(clk_phase_o == 1'b0, "R9 gated off", clk_phase_o, 0);
        check(clk_div_o == 1'b1,   "R9 div still passes", clk_div_o, 1);
        step();
        wr_div(16'hAA06, 0, "R1 leave div1");
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R1 div 6 after div1", hi * 100 + lo, 303);
        check(running_o == 1'b1, "R10 running held", running_o, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule